// File: doc/BRIEF.md
# I2C SCL Divider Parameter Search

This block picks the clock settings for an I2C bus master. It takes a requested bus speed in Hz and a fixed functional clock frequency. From these it finds a clock prescaler and two 8-bit counts: one for the SCL low phase and one for the SCL high phase. A single-cycle `start` pulse launches a search. The block then tries prescaler values one after another, starting at 0 and counting up by one. For each prescaler it computes a sample clock and a phase quotient. It stops at the first prescaler whose trimmed counts fit the 8-bit fields. When the search ends it raises `done` for one cycle together with the result. If no prescaler up to 255 fits, it raises `no_fit` instead.

For each prescaler `p` the block runs two divisions on one shared serial divider, which produces one quotient bit per cycle:
- sample = FCLK_HZ / (p + 1)
- q = sample / (2 × speed)

The low count is q − TRIM_LO and the high count is q − TRIM_HI.

The controller is a state machine with these states and transitions:
- `ST_IDLE` goes to `ST_SAMPLE_GO` on a start with a non-zero speed, or straight to `ST_FINISH` when the speed is zero.
- `ST_SAMPLE_GO` launches the sample-clock division and goes to `ST_SAMPLE_WAIT`.
- `ST_SAMPLE_WAIT` goes to `ST_PHASE_GO` when the divider finishes.
- `ST_PHASE_GO` launches the phase division and goes to `ST_PHASE_WAIT`.
- `ST_PHASE_WAIT` goes to `ST_JUDGE` when the divider finishes.
- `ST_JUDGE` goes to `ST_FINISH` on a fit or after prescaler 255. Otherwise it steps the prescaler and goes back to `ST_SAMPLE_GO`.
- `ST_FINISH` always returns to `ST_IDLE`.

Top module: `scl_param_search`

## Requirements
- R1: After reset, `busy`, `done` and `no_fit` are 0, and `psc_val`, `low_cnt` and `high_cnt` are 0.
- R2: The requested speed is doubled before it is used as a divisor. For the accepted prescaler p, with q = floor(floor(FCLK_HZ/(p+1)) / (2·speed_hz)), the outputs are `low_cnt` = q − TRIM_LO and `high_cnt` = q − TRIM_HI.
- R3: Prescalers are tried in the order 0, 1, 2, … up to 255. `psc_val` is the first one that fits.
- R4: A prescaler fits only when both trimmed counts are greater than 0, `low_cnt` ≤ 255 − TRIM_LO and `high_cnt` ≤ 255 − TRIM_HI. With the defaults, q = 255 fits, q = 256 does not fit, and q = 7 does not fit because the low count would be 0.
- R5: When no prescaler in 0..255 fits, `done` comes with `no_fit` = 1. In that case `psc_val`, `low_cnt` and `high_cnt` are 0.
- R6: A start with `speed_hz` = 0 performs no search. `done` and `no_fit` = 1 appear in the cycle after the start.
- R7: Timing of a search:
  - `busy` rises in the cycle after an accepted start.
  - The divider width is DW = max(bits needed for FCLK_HZ, SPEED_W+1).
  - Each prescaler trial takes 2·DW+5 cycles.
  - For a search that ends at prescaler k, `done` is high for exactly one cycle, (k+1)·(2·DW+5)+1 cycles after the start cycle. That cycle is the last one in which `busy` is high.
- R8: A `start` pulse while `busy` is high is ignored. The running search and its result are unaffected.
- R9: `psc_val`, `low_cnt`, `high_cnt` and `no_fit` change only in a `done` cycle and hold their values until the next `done`, whatever `speed_hz` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a search (accepted only when idle) |
| speed_hz | input | SPEED_W | Requested bus speed in Hz, sampled with start |
| busy | output | 1 | Search in progress, through the done cycle |
| done | output | 1 | One-cycle end-of-search pulse |
| no_fit | output | 1 | Last search found no prescaler (or the speed was zero) |
| psc_val | output | 8 | Chosen prescaler |
| low_cnt | output | 8 | SCL low phase count |
| high_cnt | output | 8 | SCL high phase count |

## Verification
The speeds are chosen so that the search ends at different prescalers: 400 kHz and 100 kHz fit at 0, 50 kHz at 1, and 10 kHz at 9. These runs separate a correct upward scan from one that skips or overshoots, and they confirm the cycle count per trial. Boundary speeds place the quotient exactly at 255 (fits), at 256 (moves on to prescaler 1) and at 7 (a low count of zero, so the full scan fails). A very low speed fails from the opposite side, with the quotient always too large. A zero speed, a start pulse in the middle of a search, and `speed_hz` changing while idle show that results move only in done cycles.

// File: rtl/scl_search_pkg.sv
package scl_search_pkg;

    localparam int CNT_W   = 8;
    localparam int PSC_W   = 8;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE_GO,
        ST_SAMPLE_WAIT,
        ST_PHASE_GO,
        ST_PHASE_WAIT,
        ST_JUDGE,
        ST_FINISH
    } srch_state_t;

endpackage

// File: rtl/scl_div_serial.sv
// Restoring divider: one quotient bit per cycle, W cycles after go.
module scl_div_serial #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic         fin
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [W:0]    shifted;
    logic [W:0]    trial;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, den_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem_q <= '0;
                quo_q <= num;
                den_q <= den;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (!trial[W]) begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

    assign quo = quo_q;

endmodule

// File: rtl/scl_trial_judge.sv
// Applies the two trims to a phase quotient and checks both lanes.
module scl_trial_judge
    import scl_search_pkg::*;
#(
    parameter int DW      = 32,
    parameter int TRIM_LO = 7,
    parameter int TRIM_HI = 5
) (
    input  logic [DW-1:0]    quot,
    output logic [CNT_W-1:0] lo_cnt,
    output logic [CNT_W-1:0] hi_cnt,
    output logic             fits
);
    localparam int SW = DW + 2;

    logic [CNT_W-1:0] lane_cnt [2];
    logic [1:0]       lane_ok;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int TR = (g == 0) ? TRIM_LO : TRIM_HI;
        logic signed [SW-1:0] val;
        always_comb begin
            val         = $signed({2'b00, quot}) - $signed(SW'(TR));
            lane_ok[g]  = (val > $signed(SW'(0))) &&
                          (val <= $signed(SW'(CNT_MAX - TR)));
            lane_cnt[g] = val[CNT_W-1:0];
        end
    end

    assign lo_cnt = lane_cnt[0];
    assign hi_cnt = lane_cnt[1];
    assign fits   = &lane_ok;

endmodule

// File: rtl/scl_param_search.sv
module scl_param_search
    import scl_search_pkg::*;
#(
    parameter int FCLK_HZ = 48_000_000,
    parameter int SPEED_W = 24,
    parameter int TRIM_LO = 7,
    parameter int TRIM_HI = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SPEED_W-1:0] speed_hz,
    output logic               busy,
    output logic               done,
    output logic               no_fit,
    output logic [PSC_W-1:0]   psc_val,
    output logic [CNT_W-1:0]   low_cnt,
    output logic [CNT_W-1:0]   high_cnt
);
    localparam int FCLK_BITS = $clog2(FCLK_HZ + 1);
    localparam int DW = (FCLK_BITS > SPEED_W + 1) ? FCLK_BITS : SPEED_W + 1;
    localparam logic [PSC_W-1:0] PSC_LAST = '1;

    srch_state_t state_q, state_d;

    logic [DW-1:0]    speed2_q;
    logic [DW-1:0]    sample_q;
    logic [DW-1:0]    phase_q;
    logic [PSC_W-1:0] psc_q;

    logic             div_go;
    logic [DW-1:0]    div_num;
    logic [DW-1:0]    div_den;
    logic [DW-1:0]    div_quo;
    logic             div_fin;

    logic [CNT_W-1:0] j_lo;
    logic [CNT_W-1:0] j_hi;
    logic             j_fits;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start)
                    state_d = (speed_hz == '0) ? ST_FINISH : ST_SAMPLE_GO;
            end
            ST_SAMPLE_GO:   state_d = ST_SAMPLE_WAIT;
            ST_SAMPLE_WAIT: if (div_fin) state_d = ST_PHASE_GO;
            ST_PHASE_GO:    state_d = ST_PHASE_WAIT;
            ST_PHASE_WAIT:  if (div_fin) state_d = ST_JUDGE;
            ST_JUDGE: begin
                if (j_fits || psc_q == PSC_LAST) state_d = ST_FINISH;
                else                             state_d = ST_SAMPLE_GO;
            end
            ST_FINISH:      state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs and divider control
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_FINISH);
        div_go  = (state_q == ST_SAMPLE_GO) || (state_q == ST_PHASE_GO);
        if (state_q == ST_SAMPLE_GO) begin
            div_num = DW'(FCLK_HZ);
            div_den = DW'(psc_q) + DW'(1);
        end else begin
            div_num = sample_q;
            div_den = speed2_q;
        end
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            speed2_q <= '0;
            sample_q <= '0;
            phase_q  <= '0;
            psc_q    <= '0;
            no_fit   <= 1'b0;
            psc_val  <= '0;
            low_cnt  <= '0;
            high_cnt <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        speed2_q <= DW'({speed_hz, 1'b0});
                        psc_q    <= '0;
                        if (speed_hz == '0) begin
                            no_fit   <= 1'b1;
                            psc_val  <= '0;
                            low_cnt  <= '0;
                            high_cnt <= '0;
                        end
                    end
                end
                ST_SAMPLE_WAIT: if (div_fin) sample_q <= div_quo;
                ST_PHASE_WAIT:  if (div_fin) phase_q  <= div_quo;
                ST_JUDGE: begin
                    if (j_fits) begin
                        no_fit   <= 1'b0;
                        psc_val  <= psc_q;
                        low_cnt  <= j_lo;
                        high_cnt <= j_hi;
                    end else if (psc_q == PSC_LAST) begin
                        no_fit   <= 1'b1;
                        psc_val  <= '0;
                        low_cnt  <= '0;
                        high_cnt <= '0;
                    end else begin
                        psc_q <= psc_q + PSC_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    scl_div_serial #(.W(DW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .quo   (div_quo),
        .fin   (div_fin)
    );

    scl_trial_judge #(.DW(DW), .TRIM_LO(TRIM_LO), .TRIM_HI(TRIM_HI)) u_judge (
        .quot   (phase_q),
        .lo_cnt (j_lo),
        .hi_cnt (j_hi),
        .fits   (j_fits)
    );

endmodule

// File: rtl/scl_param_search_chk.sv
module scl_param_search_chk #(
    parameter int SPEED_W = 24,
    parameter int TRIM_LO = 7,
    parameter int TRIM_HI = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [SPEED_W-1:0] speed_hz,
    input logic               busy,
    input logic               done,
    input logic               no_fit,
    input logic [7:0]         psc_val,
    input logic [7:0]         low_cnt,
    input logic [7:0]         high_cnt
);
    p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({psc_val, low_cnt, high_cnt, no_fit}));

    p_fit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_fit) |-> (low_cnt != 8'd0 && high_cnt != 8'd0 &&
                               int'(low_cnt) <= 255 - TRIM_LO &&
                               int'(high_cnt) <= 255 - TRIM_HI));

    p_trim_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_fit) |-> (int'(high_cnt) + TRIM_HI == int'(low_cnt) + TRIM_LO - TRIM_LO + TRIM_HI
                               + (int'(high_cnt) - int'(low_cnt)) - (TRIM_LO - TRIM_HI) + (TRIM_LO - TRIM_HI)
                               - (int'(high_cnt) - int'(low_cnt)) + (TRIM_LO - TRIM_HI)));

    p_fail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_fit) |-> (psc_val == 8'd0 && low_cnt == 8'd0 && high_cnt == 8'd0));

    p_zero_speed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && speed_hz == '0) |=> (done && no_fit));

endmodule

bind scl_param_search scl_param_search_chk #(
    .SPEED_W (SPEED_W),
    .TRIM_LO (TRIM_LO),
    .TRIM_HI (TRIM_HI)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .speed_hz (speed_hz),
    .busy     (busy),
    .done     (done),
    .no_fit   (no_fit),
    .psc_val  (psc_val),
    .low_cnt  (low_cnt),
    .high_cnt (high_cnt)
);

// File: tb/scl_param_search_tb.sv
module scl_param_search_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FCLK_HZ    = 48_000_000;
    localparam int SPEED_W    = 24;
    localparam int TL         = 7;
    localparam int TH         = 5;
    localparam int FBITS      = $clog2(FCLK_HZ + 1);
    localparam int DW         = (FBITS > SPEED_W + 1) ? FBITS : SPEED_W + 1;
    localparam int TRIAL      = 2 * DW + 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [SPEED_W-1:0] speed_hz = '0;
    logic               busy, done, no_fit;
    logic [7:0]         psc_val, low_cnt, high_cnt;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    scl_param_search #(.FCLK_HZ(FCLK_HZ), .SPEED_W(SPEED_W),
                       .TRIM_LO(TL), .TRIM_HI(TH)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .speed_hz(speed_hz),
        .busy(busy), .done(done), .no_fit(no_fit),
        .psc_val(psc_val), .low_cnt(low_cnt), .high_cnt(high_cnt)
    );

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural search from the requirements
    task automatic ref_search(input longint spd, output int k, output int ps,
                              output int lo, output int hi, output bit err);
        k = 255; ps = 0; lo = 0; hi = 0; err = 1'b1;
        if (spd == 0) begin
            k = -1;
            return;
        end
        for (int p = 0; p < 256; p++) begin
            longint s = FCLK_HZ / (p + 1);
            longint q = s / (2 * spd);
            longint l = q - TL;
            longint h = q - TH;
            if (l > 0 && h > 0 && l <= 255 - TL && h <= 255 - TH) begin
                k = p; ps = p; lo = int'(l); hi = int'(h); err = 1'b0;
                return;
            end
        end
    endtask

    // cycle-by-cycle reference model
    bit m_run = 1'b0;
    int m_left = 0;
    int m_ps = 0, m_lo = 0, m_hi = 0;
    bit m_err = 1'b0;
    int p_ps, p_lo, p_hi;
    bit p_err;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 1'b0; m_left = 0;
            m_ps = 0; m_lo = 0; m_hi = 0; m_err = 1'b0;
        end else if (m_run) begin
            if (m_left == 0) m_run = 1'b0;
            else begin
                m_left--;
                if (m_left == 0) begin
                    m_ps = p_ps; m_lo = p_lo; m_hi = p_hi; m_err = p_err;
                end
            end
        end else if (start) begin
            int k;
            ref_search(longint'(speed_hz), k, p_ps, p_lo, p_hi, p_err);
            m_run = 1'b1;
            m_left = (k < 0) ? 0 : (k + 1) * TRIAL;
            if (m_left == 0) begin
                m_ps = p_ps; m_lo = p_lo; m_hi = p_hi; m_err = p_err;
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            check("R7 busy model", busy, m_run);
            check("R7 done model", done, m_run && m_left == 0);
            check("R5 no_fit model", no_fit, m_err);
            check("R3 psc model", psc_val, m_ps);
            check("R2 low model", low_cnt, m_lo);
            check("R2 high model", high_cnt, m_hi);
        end
    end

    // run one search and check its result and latency
    task automatic run(input longint spd, input string tag, input bit poke);
        int k, ps, lo, hi, cyc;
        bit err;
        ref_search(spd, k, ps, lo, hi, err);
        @(negedge clk);
        start = 1'b1;
        speed_hz = SPEED_W'(spd);
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        check({tag, " R7 busy rises"}, busy, 1);
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 12) begin
                start = 1'b1;      // R8: must be ignored
                speed_hz = '0;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check({tag, " R7 latency"}, cyc, (k < 0) ? 1 : (k + 1) * TRIAL + 1);
        check({tag, " R3 psc"}, psc_val, ps);
        check({tag, " R2 low"}, low_cnt, lo);
        check({tag, " R2 high"}, high_cnt, hi);
        check({tag, " R5 no_fit"}, no_fit, err);
        @(negedge clk);
        check({tag, " R7 busy falls"}, busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 no_fit", no_fit, 0);
        check("R1 outs", {psc_val, low_cnt, high_cnt}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(400_000, "400k", 1'b0);
        check("R2 400k low literal", low_cnt, 53);
        check("R2 400k high literal", high_cnt, 55);
        run(100_000, "100k", 1'b0);
        run(50_000, "50k", 1'b0);
        check("R3 50k psc literal", psc_val, 1);
        run(10_000, "10k", 1'b0);
        check("R3 10k psc literal", psc_val, 9);
        run(94_000, "R4 q255", 1'b0);
        check("R4 q255 low literal", low_cnt, 248);
        run(93_750, "R4 q256", 1'b0);
        check("R4 q256 psc literal", psc_val, 1);
        run(3_000_000, "R4 q8", 1'b0);
        check("R4 q8 low literal", low_cnt, 1);
        run(3_300_000, "R5 q7", 1'b0);
        check("R5 q7 fail", no_fit, 1);
        run(100, "R5 slow", 1'b0);
        run(0, "R6 zero", 1'b0);
        check("R6 zero fail", no_fit, 1);
        run(400_000, "R8 poke", 1'b1);
        check("R8 result kept", low_cnt, 53);

        // R9: input changes while idle must not move the outputs
        speed_hz = SPEED_W'(12345);
        repeat (20) @(negedge clk);
        check("R9 psc held", psc_val, 0);
        check("R9 low held", low_cnt, 53);
        check("R9 high held", high_cnt, 55);
        check("R9 busy idle", busy, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule